// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block arbitrates among eight interrupt request lines. It holds a pending-request vector, an in-service vector and a pointer that names the level currently holding the lowest priority. The remaining levels rank upward from that level in circular order. When an unmasked pending request outranks every level now in service, the block raises its interrupt output and presents the index of the winning request.

Acknowledge logic outside the block pulses a strobe to move the winner from pending to in-service. In automatic end-of-interrupt operation it pulses a second strobe to retire a level. Software-level commands arrive as a three-bit code with a level field. These commands retire in-service levels, and some of them also move the lowest-priority pointer. Requests are captured on rising edges or by level, as chosen by a mode input. A special-mask mode input lets in-service levels stop blocking requests of lower rank.

Top module: `irq_rot_arbiter`

## Requirements
- R1: After reset the pending and in-service vectors are zero and `prio_low` is 7, so IR0 ranks highest and IR7 lowest.
- R2: `int_out` is 1 only when some pending bit not set in `irq_mask` ranks strictly above every set in-service bit (special mask off). `win_idx` is then the highest-ranked such pending level.
- R3: Rank is circular. Level `prio_low`+1 (mod 8) is highest, and each following level is one step lower, ending at `prio_low`.
- R4: A cycle with `ack_set` high while `int_out` is 1 sets in-service bit `win_idx` and clears that pending bit on the next edge.
- R5: `cmd_code` bit 2 selects rotation, bit 1 selects use of `cmd_level`, and bit 0 marks end-of-interrupt. Code 001 clears the highest-ranked set in-service bit. Code 011 clears in-service bit `cmd_level`.
- R6: Code 101 clears the highest-ranked set in-service bit and loads its index into `prio_low`.
- R7: Code 111 clears in-service bit `cmd_level` and loads `cmd_level` into `prio_low`. Code 110 loads `cmd_level` into `prio_low` and leaves the in-service vector unchanged.
- R8: Code 100 enables and code 000 disables rotation on automatic end-of-interrupt. `aeoi_done` clears in-service bit `aeoi_level`, and it also loads `aeoi_level` into `prio_low` while rotation is enabled. Code 010 changes nothing.
- R9: With `level_mode` at 1, each pending bit copies its request line on every edge, except in the edge where that level is acknowledged.
- R10: With `level_mode` at 0, a low-to-high transition of a line sets its pending bit. The bit stays set until acknowledged, and a line that stays high raises no new request.
- R11: With `special_mask` at 1, any pending, unmasked level whose in-service bit is clear may raise `int_out`, whatever ranks the in-service levels have.
- R12: Setting a mask bit hides that pending bit from arbitration but does not clear it. The request wins again once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | 8 | Request lines, bit i is level i |
| irq_mask | input | 8 | Mask, 1 hides a level from arbitration |
| level_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| special_mask | input | 1 | 1 = in-service levels do not block lower ranks |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code {rotate, use-level, eoi} |
| cmd_level | input | 3 | Level field for commands |
| ack_set | input | 1 | Acknowledge: move winner to in-service |
| aeoi_done | input | 1 | Automatic end-of-interrupt strobe |
| aeoi_level | input | 3 | Level retired by `aeoi_done` |
| int_out | output | 1 | Interrupt request to processor |
| win_idx | output | 3 | Winning level index, valid while `int_out` is 1 |
| irr_q | output | 8 | Pending request vector |
| isr_q | output | 8 | In-service vector |
| prio_low | output | 3 | Level holding lowest priority |

## Verification
The hardest state to reach is a rotated ordering in which a nested acknowledge, a special-mask override and a masked but still pending request all meet. Each of these requires the in-service vector and the pointer to be built up first through a chain of acknowledges and commands. The stimulus walks a single sequence that builds that history. Nested requests are acknowledged, retired by each end-of-interrupt flavour, the pointer is rotated away from reset, and then masking, automatic retirement, level capture and special mask are tried under the rotated order. A behavioural model follows every clock and catches divergence anywhere along the chain.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;

    localparam int NUM_IRQ_DFLT = 8;

    typedef enum logic [2:0] {
        CMD_ROT_AEOI_OFF = 3'b000,
        CMD_EOI_TOP      = 3'b001,
        CMD_NOP          = 3'b010,
        CMD_EOI_LVL      = 3'b011,
        CMD_ROT_AEOI_ON  = 3'b100,
        CMD_ROT_EOI_TOP  = 3'b101,
        CMD_SET_LOW      = 3'b110,
        CMD_ROT_EOI_LVL  = 3'b111
    } prio_cmd_e;

    typedef struct packed {
        logic clr_top;   // clear highest-ranked in-service bit
        logic clr_lvl;   // clear in-service bit named by level field
        logic move_top;  // pointer takes index of highest in-service bit
        logic move_lvl;  // pointer takes level field
        logic rot_on;
        logic rot_off;
    } cmd_act_t;

    // level that sits k steps below the top, given the bottom level
    function automatic int level_at(input int low, input int k, input int n);
        return (low + 1 + k) % n;
    endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         level_mode,
    input  logic [N-1:0] line,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                irr[g] <= 1'b0;
            else if (level_mode)
                irr[g] <= line[g] & ~clr[g];
            else
                irr[g] <= (irr[g] & ~clr[g]) | (line[g] & ~prev_q[g]);
        end
    end

endmodule

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] low,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] rank
);
    import irq_rot_pkg::*;

    // scan from the bottom rank upward so the top-ranked hit is kept last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[level_at(int'(low), k, N)]) begin
                found = 1'b1;
                idx   = IW'(level_at(int'(low), k, N));
                rank  = IW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode (
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_code,
    output irq_rot_pkg::cmd_act_t act
);
    import irq_rot_pkg::*;

    prio_cmd_e code;
    assign code = prio_cmd_e'(cmd_code);

    always_comb begin
        act = '0;
        if (cmd_valid) begin
            unique case (code)
                CMD_EOI_TOP:      act.clr_top = 1'b1;
                CMD_EOI_LVL:      act.clr_lvl = 1'b1;
                CMD_ROT_EOI_TOP:  begin act.clr_top = 1'b1; act.move_top = 1'b1; end
                CMD_ROT_EOI_LVL:  begin act.clr_lvl = 1'b1; act.move_lvl = 1'b1; end
                CMD_SET_LOW:      act.move_lvl = 1'b1;
                CMD_ROT_AEOI_ON:  act.rot_on   = 1'b1;
                CMD_ROT_AEOI_OFF: act.rot_off  = 1'b1;
                CMD_NOP:          act = '0;
                default:          act = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_rot_arbiter.sv
module irq_rot_arbiter #(
    parameter int N  = irq_rot_pkg::NUM_IRQ_DFLT,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_line,
    input  logic [N-1:0]  irq_mask,
    input  logic          level_mode,
    input  logic          special_mask,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [IW-1:0] cmd_level,
    input  logic          ack_set,
    input  logic          aeoi_done,
    input  logic [IW-1:0] aeoi_level,
    output logic          int_out,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  irr_q,
    output logic [N-1:0]  isr_q,
    output logic [IW-1:0] prio_low
);
    import irq_rot_pkg::*;

    localparam logic [IW-1:0] LOW_RST = IW'(N - 1);

    cmd_act_t      act;
    logic          rot_aeoi_q;
    logic [N-1:0]  cand;
    logic          req_found, isr_found;
    logic [IW-1:0] req_idx, req_rank, isr_idx, isr_rank;
    logic [N-1:0]  isr_set, isr_clr;
    logic [IW-1:0] low_d;

    irq_req_capture #(.N(N)) u_cap (
        .clk(clk), .rst(rst), .level_mode(level_mode),
        .line(irq_line), .clr(isr_set), .irr(irr_q)
    );

    assign cand = special_mask ? (irr_q & ~irq_mask & ~isr_q) : (irr_q & ~irq_mask);

    irq_rot_pick #(.N(N), .IW(IW)) u_pick_req (
        .vec(cand), .low(prio_low),
        .found(req_found), .idx(req_idx), .rank(req_rank)
    );

    irq_rot_pick #(.N(N), .IW(IW)) u_pick_isr (
        .vec(isr_q), .low(prio_low),
        .found(isr_found), .idx(isr_idx), .rank(isr_rank)
    );

    irq_cmd_decode u_dec (
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .act(act)
    );

    assign int_out = req_found && (special_mask || !isr_found || (req_rank < isr_rank));
    assign win_idx = req_idx;

    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        if (ack_set && int_out)          isr_set[req_idx]    = 1'b1;
        if (act.clr_top && isr_found)    isr_clr[isr_idx]    = 1'b1;
        if (act.clr_lvl)                 isr_clr[cmd_level]  = 1'b1;
        if (aeoi_done)                   isr_clr[aeoi_level] = 1'b1;
    end

    always_comb begin
        low_d = prio_low;
        if (act.move_top && isr_found)      low_d = isr_idx;
        else if (act.move_lvl)              low_d = cmd_level;
        else if (aeoi_done && rot_aeoi_q)   low_d = aeoi_level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q      <= '0;
            prio_low   <= LOW_RST;
            rot_aeoi_q <= 1'b0;
        end else begin
            isr_q    <= (isr_q & ~isr_clr) | isr_set;
            prio_low <= low_d;
            if (act.rot_on)       rot_aeoi_q <= 1'b1;
            else if (act.rot_off) rot_aeoi_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_rot_arbiter_chk.sv
module irq_rot_arbiter_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  irq_mask,
    input logic          cmd_valid,
    input logic [2:0]    cmd_code,
    input logic [IW-1:0] cmd_level,
    input logic          ack_set,
    input logic          aeoi_done,
    input logic          int_out,
    input logic [IW-1:0] win_idx,
    input logic [N-1:0]  irr_q,
    input logic [N-1:0]  isr_q,
    input logic [IW-1:0] prio_low
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (isr_q == '0 && irr_q == '0 && prio_low == IW'(N - 1))); // R1

    AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr_q & ~irq_mask) != '0)); // R2

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_set && int_out) |=> isr_q[$past(win_idx)]); // R4

    AST_LVL_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'b011 && !ack_set) |=> !isr_q[$past(cmd_level)]); // R5

    AST_SET_LOW_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'b110 && !ack_set && !aeoi_done)
        |=> (prio_low == $past(cmd_level) && isr_q == $past(isr_q))); // R7

    AST_NOP_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'b010 && !aeoi_done) |=> $stable(prio_low)); // R8

endmodule

bind irq_rot_arbiter irq_rot_arbiter_chk #(.N(N), .IW(IW)) u_chk (.*);

// File: tb/irq_rot_arbiter_tb.sv
module irq_rot_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_line = '0, irq_mask = '0;
    logic       level_mode = 1'b0, special_mask = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = '0, cmd_level = '0;
    logic       ack_set = 1'b0, aeoi_done = 1'b0;
    logic [2:0] aeoi_level = '0;
    logic       int_out;
    logic [2:0] win_idx, prio_low;
    logic [7:0] irr_q, isr_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_rot_arbiter dut_i (
        .clk(clk), .rst(rst), .irq_line(irq_line), .irq_mask(irq_mask),
        .level_mode(level_mode), .special_mask(special_mask),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_level(cmd_level),
        .ack_set(ack_set), .aeoi_done(aeoi_done), .aeoi_level(aeoi_level),
        .int_out(int_out), .win_idx(win_idx), .irr_q(irr_q), .isr_q(isr_q),
        .prio_low(prio_low)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_irr = '0, m_isr = '0, m_prev = '0;
    int m_low = 7;
    bit m_rot = 0;

    function automatic int m_rank(input int lvl, input int low);
        return (lvl - low - 1 + 16) % 8;
    endfunction

    function automatic int m_best(input logic [7:0] v, input int low);
        int b = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && (b < 0 || m_rank(i, low) < m_rank(b, low))) b = i;
        return b;
    endfunction

    function automatic int m_winner();
        logic [7:0] c;
        c = m_irr & ~irq_mask;
        if (special_mask) c = c & ~m_isr;
        return m_best(c, m_low);
    endfunction

    function automatic bit m_int();
        int w = m_winner();
        int s = m_best(m_isr, m_low);
        if (w < 0) return 0;
        if (special_mask || s < 0) return 1;
        return m_rank(w, m_low) < m_rank(s, m_low);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_irr = '0; m_isr = '0; m_prev = '0; m_low = 7; m_rot = 0;
        end else begin
            logic [7:0] setv, clrv;
            int top, w, new_low;
            setv = '0; clrv = '0;
            w = m_winner();
            top = m_best(m_isr, m_low);
            new_low = m_low;
            if (ack_set && m_int()) setv[w] = 1'b1;
            if (cmd_valid) begin
                case (cmd_code)
                    3'b001: if (top >= 0) clrv[top] = 1'b1;
                    3'b011: clrv[cmd_level] = 1'b1;
                    3'b101: if (top >= 0) begin clrv[top] = 1'b1; new_low = top; end
                    3'b111: begin clrv[cmd_level] = 1'b1; new_low = cmd_level; end
                    3'b110: new_low = cmd_level;
                    3'b100: m_rot = 1;
                    3'b000: m_rot = 0;
                    default: ;
                endcase
            end
            if (aeoi_done) begin
                clrv[aeoi_level] = 1'b1;
                if (m_rot && new_low == m_low && !(cmd_valid && cmd_code[1])) new_low = aeoi_level;
            end
            if (level_mode) m_irr = irq_line & ~setv;
            else            m_irr = (m_irr & ~setv) | (irq_line & ~m_prev);
            m_prev = irq_line;
            m_isr = (m_isr & ~clrv) | setv;
            m_low = new_low;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit mi = m_int();
        chk(int_out == mi, "R2 model int", int_out, mi);
        chk(irr_q == m_irr, "R9/R10 model irr", irr_q, m_irr);
        chk(isr_q == m_isr, "R4/R5 model isr", isr_q, m_isr);
        chk(prio_low == 3'(m_low), "R3/R6 model low", prio_low, m_low);
        if (mi) chk(win_idx == 3'(m_winner()), "R3 model win", win_idx, m_winner());
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        cmd_valid = 1'b0; ack_set = 1'b0; aeoi_done = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] code, input logic [2:0] lvl);
        cmd_valid = 1'b1; cmd_code = code; cmd_level = lvl;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        step();
        // R1: reset state
        chk(isr_q == 8'h00 && irr_q == 8'h00, "R1 vectors", {isr_q, irr_q}, 0);
        chk(prio_low == 3'd7, "R1 low", prio_low, 7);
        chk(int_out == 1'b0, "R1 int", int_out, 0);

        // R10/R3: edge capture, IR2 beats IR5 in nested order
        irq_line = 8'h24; step();
        chk(irr_q == 8'h24, "R10 capture", irr_q, 8'h24);
        chk(int_out && win_idx == 3'd2, "R3 win", win_idx, 2);
        ack_set = 1'b1; step();
        chk(isr_q == 8'h04 && irr_q == 8'h20, "R4 ack", {isr_q, irr_q}, 16'h0420);
        chk(int_out == 1'b0, "R2 blocked by higher in-service", int_out, 0);

        // nested: IR1 outranks in-service IR2
        irq_line = 8'h26; step();
        chk(int_out && win_idx == 3'd1, "R2 nested win", win_idx, 1);
        ack_set = 1'b1; step();
        chk(isr_q == 8'h06, "R4 nested isr", isr_q, 8'h06);

        cmd(3'b001, 3'd0);
        chk(isr_q == 8'h04, "R5 top eoi", isr_q, 8'h04);
        cmd(3'b011, 3'd2);
        chk(isr_q == 8'h00 && int_out && win_idx == 3'd5, "R5 level eoi", isr_q, 0);
        ack_set = 1'b1; step();
        cmd(3'b101, 3'd0);
        chk(isr_q == 8'h00 && prio_low == 3'd5, "R6 rotate top eoi", prio_low, 5);

        // rotated order: IR6 highest, so IR6 beats IR0
        irq_line = 8'h00; step();
        irq_line = 8'h41; step();
        chk(int_out && win_idx == 3'd6, "R3 rotated win", win_idx, 6);
        cmd(3'b110, 3'd6);
        chk(prio_low == 3'd6 && isr_q == 8'h00 && win_idx == 3'd0, "R7 set low", win_idx, 0);
        ack_set = 1'b1; step();
        chk(isr_q == 8'h01 && irr_q == 8'h40 && !int_out, "R4 after set low", isr_q, 1);
        cmd(3'b111, 3'd0);
        chk(isr_q == 8'h00 && prio_low == 3'd0 && win_idx == 3'd6, "R7 rotate level eoi", prio_low, 0);

        // R12: masking hides but keeps the request
        irq_mask = 8'h40; step();
        chk(!int_out && irr_q == 8'h40, "R12 masked kept", irr_q, 8'h40);
        irq_mask = 8'h00; step();
        chk(int_out && win_idx == 3'd6, "R12 unmasked wins", win_idx, 6);

        // R8: rotate-in-auto-EOI
        cmd(3'b100, 3'd0);
        ack_set = 1'b1; step();
        aeoi_done = 1'b1; aeoi_level = 3'd6; step();
        chk(isr_q == 8'h00 && prio_low == 3'd6, "R8 auto rotate", prio_low, 6);
        cmd(3'b010, 3'd3);
        chk(prio_low == 3'd6 && isr_q == 8'h00, "R8 nop", prio_low, 6);
        cmd(3'b000, 3'd0);

        // R10: line held high gives no new request
        step(); step();
        chk(irr_q == 8'h00, "R10 no re-capture while high", irr_q, 0);

        // R9: level capture follows the line
        irq_line = 8'h00; level_mode = 1'b1; step();
        irq_line = 8'h08; step();
        chk(irr_q == 8'h08, "R9 level high", irr_q, 8'h08);
        irq_line = 8'h00; step();
        chk(irr_q == 8'h00, "R9 level low", irr_q, 0);

        // R11: special mask lets lower rank through
        irq_line = 8'h08; step();
        ack_set = 1'b1; step();
        irq_line = 8'h18; step();
        chk(int_out == 1'b0, "R11 blocked before special mask", int_out, 0);
        special_mask = 1'b1; step();
        chk(int_out && win_idx == 3'd4, "R11 special mask win", win_idx, 4);
        special_mask = 1'b0; step();

        finish_run();
    end

endmodule